// File: doc/BRIEF.md
# Shared Expansion Bus Arbiter

This block decides, cycle by cycle, whether the processor core or an outside expansion device drives a shared address, data, direction and read/write strobe bus. The outside device asks for the bus by pulling an active-low request line low. The line idles high, or floats high through a pull-up, and the core then runs with no stall. The request is asynchronous to the core clock, so the arbiter passes it through a chain of synchronizer flops before it acts on it.

The core is not interrupted in the middle of an access. If the core holds the bus and is partway through an access when the request arrives, it completes that access. It hands the bus over only when it next asks for the bus. From then on, any cycle in which the core wants the bus without owning it is held off by dropping the core's clock enable. Once the request line returns high, ownership goes back to the core and the clock enable rises. The ownership flag is also driven in inverted form, so that the expansion device sees an active-low flag that matches its request line. Every bus driver enable follows ownership, so the core's drivers are tri-stated whenever the core does not own the bus.

Top module: `ebus_arbiter`

## Requirements
- R1: While `ext_req_n` stays high (1 = idle), `core_owns` stays 1 and `core_clk_en` stays 1 for any pattern of `core_need`.
- R2: In any cycle where `core_need` is 1 and the core either does not own the bus or is handing it over in that cycle, `core_clk_en` is 0 in that same cycle, with no clock edge in between.
- R3: When the core does not own the bus and the synchronized request reads idle at a clock edge, `core_owns` becomes 1 at that edge. Because of the synchronizer, this is the third rising edge at which `ext_req_n` is sampled high.
- R4: An access in progress is not aborted. If the core owns the bus, `core_need` was 1 and the core was running at the previous edge, then the core keeps the bus for as long as `core_need` stays 1. A request that arrives while the core owns the bus with `core_need` at 0 does not remove ownership.
- R5: The request passes through a two-stage synchronizer. A change on `ext_req_n` takes effect only at the second rising edge after the one that first samples it, and ownership is lost only at an edge where the synchronized request is active, the core owns the bus, `core_need` is 1 and no access is in progress.
- R6: `core_owns_n` is always the logical inverse of `core_owns`.
- R7: All four driver enables in `drv_oe` equal `core_owns`. The bit order is 0 = address, 1 = data, 2 = direction, 3 = read/write strobe, and 1 means the core's driver is enabled.
- R8: While `rst_n` is low, and right after its release, the core owns the bus, the clock enable is 1 and the synchronizer reads idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_need | input | 1 | Core wants the bus this cycle |
| ext_req_n | input | 1 | Asynchronous active-low bus request from the expansion device |
| core_owns | output | 1 | Core owns the bus |
| core_owns_n | output | 1 | Active-low ownership flag for the expansion connector |
| core_clk_en | output | 1 | Core clock enable; 0 pauses the core |
| drv_oe | output | 4 | Driver enables: [0] address, [1] data, [2] direction, [3] strobes |

## Verification
The clock enable depends combinationally on `core_need`, so it is due in the same cycle as the input. The bench drives inputs on the falling edge and compares one time unit later. Ownership, its inverse and the driver enables are registered, so they change at the first rising edge after the cause. A change on the request line reaches them only two edges after it is first sampled. The behavioural model in the bench keeps the request history in a queue as deep as the synchronizer, and the bench compares every output against the model on every cycle, so any result that comes early or late shows up as a mismatch in the cycle where it happens.

// File: rtl/ebus_arb_pkg.sv
package ebus_arb_pkg;
  localparam int unsigned DRV_ADDR   = 0;
  localparam int unsigned DRV_DATA   = 1;
  localparam int unsigned DRV_DIR    = 2;
  localparam int unsigned DRV_STROBE = 3;
  localparam int unsigned DRV_COUNT  = 4;

  typedef struct packed {
    logic owns;    // core owns the bus
    logic in_acc;  // core is mid-access while owning
  } arb_state_t;

  localparam arb_state_t ARB_RESET = '{owns: 1'b1, in_acc: 1'b0};
endpackage

// File: rtl/ebus_req_sync.sv
module ebus_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  output logic req_seen
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = req_n_async;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], req_n_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign req_seen = ~stg_q[LAST];
endmodule

// File: rtl/ebus_owner.sv
module ebus_owner
  import ebus_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic core_need,
  input  logic req_seen,
  output logic owns,
  output logic clk_en
);
  arb_state_t st_q;
  arb_state_t st_d;
  logic       yield;

  // Hand over only at a fresh bus-need point, never mid-access.
  always_comb yield = st_q.owns & req_seen & core_need & ~st_q.in_acc;

  always_comb begin
    st_d = st_q;
    if (st_q.owns) begin
      st_d.owns   = ~yield;
      st_d.in_acc = core_need & ~yield;
    end else begin
      st_d.owns   = ~req_seen;
      st_d.in_acc = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_RESET;
    else        st_q <= st_d;
  end

  assign owns   = st_q.owns;
  assign clk_en = ~core_need | (st_q.owns & ~yield);
endmodule

// File: rtl/ebus_drv_en.sv
module ebus_drv_en #(
  parameter int unsigned NUM_DRV = 4
) (
  input  logic               owns,
  output logic [NUM_DRV-1:0] oe
);
  generate
    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
      assign oe[g] = owns;
    end
  endgenerate
endmodule

// File: rtl/ebus_arbiter.sv
module ebus_arbiter
  import ebus_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_DRV     = DRV_COUNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_need,
  input  logic               ext_req_n,
  output logic               core_owns,
  output logic               core_owns_n,
  output logic               core_clk_en,
  output logic [NUM_DRV-1:0] drv_oe
);
  logic req_seen;

  ebus_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n_async(ext_req_n),
    .req_seen   (req_seen)
  );

  ebus_owner u_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_need(core_need),
    .req_seen (req_seen),
    .owns     (core_owns),
    .clk_en   (core_clk_en)
  );

  ebus_drv_en #(.NUM_DRV(NUM_DRV)) u_drv (
    .owns(core_owns),
    .oe  (drv_oe)
  );

  assign core_owns_n = ~core_owns;
endmodule

// File: rtl/ebus_arbiter_chk.sv
module ebus_arbiter_chk #(
  parameter int unsigned NUM_DRV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               core_need,
  input logic               ext_req_n,
  input logic               core_owns,
  input logic               core_owns_n,
  input logic               core_clk_en,
  input logic [NUM_DRV-1:0] drv_oe
);
  p_oe_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe == {NUM_DRV{core_owns}});

  p_flag_inverse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_owns_n == ~core_owns);

  p_stall_unowned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_need && !core_owns) |-> !core_clk_en);

  p_keep_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_owns && core_need && core_clk_en) |=> (!core_need || core_owns));

  p_regain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_owns && $past(ext_req_n, 2)) |=> core_owns);

  p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_owns && $past(ext_req_n, 2)) |=> core_owns);

  p_idle_runs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (core_owns && core_need && $past(ext_req_n, 2)) |-> core_clk_en);

  p_reset_state_r8: assert property (@(posedge clk)
    !rst_n |=> (core_owns && core_clk_en));
endmodule

bind ebus_arbiter ebus_arbiter_chk #(.NUM_DRV(NUM_DRV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_need  (core_need),
  .ext_req_n  (ext_req_n),
  .core_owns  (core_owns),
  .core_owns_n(core_owns_n),
  .core_clk_en(core_clk_en),
  .drv_oe     (drv_oe)
);

// File: tb/ebus_arbiter_tb.sv
module ebus_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int NDRV       = 4;

  logic            clk;
  logic            rst_n;
  logic            core_need;
  logic            ext_req_n;
  logic            core_owns;
  logic            core_owns_n;
  logic            core_clk_en;
  logic [NDRV-1:0] drv_oe;

  int n_cmp;
  int n_bad;
  int cyc;
  bit done;

  // behavioural reference state
  int q_hist[$];
  bit m_owns;
  bit m_busy;

  ebus_arbiter #(.SYNC_STAGES(SYNC), .NUM_DRV(NDRV)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_need  (core_need),
    .ext_req_n  (ext_req_n),
    .core_owns  (core_owns),
    .core_owns_n(core_owns_n),
    .core_clk_en(core_clk_en),
    .drv_oe     (drv_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic bit m_req();
    return q_hist[SYNC-1] == 0;
  endfunction

  function automatic bit m_yield(input bit need);
    return m_owns && m_req() && need && !m_busy;
  endfunction

  task automatic model_reset();
    q_hist.delete();
    for (int i = 0; i < SYNC; i++) q_hist.push_back(1);
    m_owns = 1'b1;
    m_busy = 1'b0;
  endtask

  task automatic compare(input string ctx);
    bit exp_en;
    exp_en = !core_need || (m_owns && !m_yield(core_need));
    chk({ctx, " R2/R1 clk_en"}, core_clk_en, exp_en);
    chk({ctx, " R3/R4/R5 owns"}, core_owns, m_owns);
    chk({ctx, " R6 owns_n"}, core_owns_n, !m_owns);
    chk({ctx, " R7 drv_oe"}, drv_oe, m_owns ? 4'hF : 4'h0);
  endtask

  task automatic step(input bit need, input bit req_n, input string ctx);
    bit y;
    @(negedge clk);
    core_need = need;
    ext_req_n = req_n;
    #1;
    compare(ctx);
    y = m_yield(need);
    @(posedge clk);
    cyc++;
    if (m_owns) begin
      m_busy = need && !y;
      m_owns = !y;
    end else begin
      m_owns = !m_req();
      m_busy = 1'b0;
    end
    q_hist.push_front(req_n);
    void'(q_hist.pop_back());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; done = 0;
    rst_n = 1'b0;
    core_need = 1'b0;
    ext_req_n = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    // R8 reset state
    chk("R8 reset owns", core_owns, 1);
    chk("R8 reset clk_en", core_clk_en, 1);
    chk("R8 reset drv_oe", drv_oe, 4'hF);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: idle request, need toggles
    for (int i = 0; i < 12; i++) step(i[0] ^ i[2], 1'b1, "R1 idle");

    // R4: request while core idle keeps bus
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R4 idle-core request");
    // R2: fresh need stalls and yields
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R2 stall");
    // R3: release, regain after sync
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R3 release");

    // R4: access in progress then request arrives
    step(1'b1, 1'b1, "R4 start access");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R4 mid access");
    step(1'b0, 1'b0, "R4 access end");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R4 next need yields");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R3 release idle core");

    // R5: single-cycle request pulse seen two edges later
    step(1'b1, 1'b0, "R5 pulse");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R5 after pulse");
    step(1'b0, 1'b1, "R5 gap");
    step(1'b1, 1'b0, "R5 pulse fresh need");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R5 after pulse 2");

    // mixed pattern
    for (int i = 0; i < 40; i++) step(i % 3 != 0, (i / 5) % 2 == 0, "R2/R3 mixed");

    // R8: reset mid-stall
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R8 pre-reset stall");
    @(negedge clk);
    rst_n = 1'b0;
    core_need = 1'b1;
    #1;
    model_reset();
    chk("R8 async reset owns", core_owns, 1);
    chk("R8 async reset clk_en", core_clk_en, 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R8 after reset");

    finish_run();
  end
endmodule